// File: doc/BRIEF.md
# Accumulative Parallel Counter

This block holds a q-bit count and, on every enabled clock, adds to it the number of asserted lines in an n-bit increment vector. It is the multi-input form of a sequential up counter: with a single increment line it simply steps by one per enabled cycle. The number of set lines among all but the last increment line comes from a tree of ripple-carry adders. Each level of the tree is one bit wider than the level above it. The final q-bit adder takes the stored count as one operand and the tree result as the other, and the last increment line enters it as the carry-in.

The carry out of that final adder is registered beside the count. This makes the block usable as a running threshold detector. If the count is preset to 2^q - k, the flag rises on the update in which the accumulated number of ones first reaches k. A load strobe presets the count and takes priority over the enable.

Top module: `acc_par_counter`

## Requirements
- R1: While the synchronous active-low reset is sampled low at a rising clock edge, the count and the carry flag both become zero.
- R2: When load is high at an edge, the count takes the load value and the carry flag becomes 0, whatever the enable and increment inputs are.
- R3: When load is low and enable is high at an edge, the count becomes (old count + number of ones in the increment vector) modulo 2^q.
- R4: On such an enabled update, the carry flag becomes 1 exactly when old count + number of ones is at least 2^q, and 0 otherwise.
- R5: When load and enable are both low, the count and the carry flag keep their values, whatever the increment vector holds.
- R6: Every increment line carries weight one, including the highest-numbered line that feeds the final adder's carry-in. With all N_INC lines set, the count advances by N_INC.
- R7: With the count preset to 2^q - k and k ones then accumulated over several enabled cycles, the flag stays 0 on every update before the total reaches k and is 1 on the update where it reaches k.
- R8: With only increment line 0 driven, each enabled cycle adds one. Stepping from 2^q - 1 wraps the count to 0 with the flag set to 1.
- R9: Each result appears at the outputs after the rising edge that samples the inputs, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Preset strobe, wins over enable |
| load_val_i | input | CNT_W | Value written to the count on a load |
| en_i | input | 1 | Accumulate enable |
| inc_i | input | N_INC | Increment lines, each worth one |
| count_o | output | CNT_W | Stored count |
| carry_o | output | 1 | Registered carry out of the most recent update |

## Verification
Both the count and the carry flag are registered, so every effect of a load, enable, hold or reset is due at the rising edge that samples it and is visible for the whole cycle that follows. The bench therefore changes inputs on the falling edge. It compares both outputs against its own modulo-2^q accumulator 1 ns after the next rising edge, one check per output per stepped cycle. Hold and threshold checks span several consecutive cycles, so that a flag set too early or lost on a hold shows up in the cycle it is wrong.

// File: rtl/apc_pkg.sv
// Package: shared types for the accumulative parallel counter.
// Assumes nothing beyond standard SystemVerilog.
package apc_pkg;

    // Kind of register update selected for a cycle.
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_ADD  = 2'd1,
        UPD_LOAD = 2'd2
    } upd_e;

    // Priority decode: a load wins over an enable, and an enable wins over a hold.
    function automatic upd_e pick_update(input logic ld, input logic en);
        if (ld) begin
            return UPD_LOAD;
        end
        if (en) begin
            return UPD_ADD;
        end
        return UPD_HOLD;
    endfunction

endpackage

// File: rtl/apc_full_adder.sv
// One-bit full adder cell.
// Purely combinational; assumes nothing about its neighbours.
module apc_full_adder (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    logic half_x;

    // Sum and majority carry.
    always_comb begin
        half_x = a_i ^ b_i;
        s_o    = half_x ^ c_i;
        c_o    = (a_i & b_i) | (c_i & half_x);
    end

endmodule

// File: rtl/apc_rca.sv
// W-bit ripple-carry adder with carry-in and carry-out.
// Assumes W >= 1; the carry ripples from bit 0 upward.
module apc_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    output logic [W-1:0] s_o,
    output logic         c_o
);

    logic [W:0] chain;

    assign chain[0] = c_i;

    // One full-adder cell per bit position.
    for (genvar b = 0; b < W; b++) begin : g_bit
        apc_full_adder u_fa (
            .a_i(a_i[b]),
            .b_i(b_i[b]),
            .c_i(chain[b]),
            .s_o(s_o[b]),
            .c_o(chain[b+1])
        );
    end

    assign c_o = chain[W];

endmodule

// File: rtl/apc_popcount_tree.sv
// Population count of 2^CNT_W - 1 bits built from ripple-carry adders.
// Level lv (1 .. CNT_W-1) holds 2^(CNT_W-1-lv) adders, each lv bits wide.
// Each adder sums two results of the level above and takes one spare
// input bit as its carry-in. Bits 0 .. 2^(CNT_W-1)-1 are the leaf operands.
// The remaining bits are used as carry-ins, level by level.
// Assumes CNT_W >= 2.
module apc_popcount_tree #(
    parameter int CNT_W = 4
) (
    input  logic [(1<<CNT_W)-2:0] bits_i,
    output logic [CNT_W-1:0]      sum_o
);

    localparam int TREE_IN = (1 << CNT_W) - 1;

    for (genvar lv = 1; lv < CNT_W; lv++) begin : g_lvl
        localparam int NODES = 1 << (CNT_W - 1 - lv);
        localparam int CBASE = TREE_IN + 1 - (1 << (CNT_W - lv));

        logic [lv:0] node [NODES];

        for (genvar j = 0; j < NODES; j++) begin : g_node
            logic [lv-1:0] op_a;
            logic [lv-1:0] op_b;
            logic [lv-1:0] part_s;
            logic          part_c;

            if (lv == 1) begin : g_leaf
                // Leaf adders take raw input bits.
                assign op_a = bits_i[2*j];
                assign op_b = bits_i[2*j+1];
            end else begin : g_inner
                // Inner adders take two results of the level above.
                assign op_a = g_lvl[lv-1].node[2*j];
                assign op_b = g_lvl[lv-1].node[2*j+1];
            end

            apc_rca #(.W(lv)) u_add (
                .a_i(op_a),
                .b_i(op_b),
                .c_i(bits_i[CBASE+j]),
                .s_o(part_s),
                .c_o(part_c)
            );

            assign node[j] = {part_c, part_s};
        end
    end

    assign sum_o = g_lvl[CNT_W-1].node[0];

endmodule

// File: rtl/acc_par_counter.sv
// Accumulative parallel counter (top).
// Adds the number of set increment lines to a stored CNT_W-bit count on each
// enabled clock. Lines 0 .. N_INC-2 go through the adder tree, and line N_INC-1
// is the carry-in of the final adder. The final adder's carry out is
// registered as carry_o. Assumes CNT_W >= 2 and 1 <= N_INC <= 2^CNT_W.
module acc_par_counter
    import apc_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int N_INC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             en_i,
    input  logic [N_INC-1:0] inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             carry_o
);

    localparam int TREE_IN = (1 << CNT_W) - 1;

    logic [TREE_IN-1:0] tree_bits;
    logic               last_inc;
    logic [CNT_W-1:0]   tree_sum;
    logic [CNT_W-1:0]   nxt_count;
    logic               nxt_carry;
    logic [CNT_W-1:0]   count_q;
    logic               carry_q;
    upd_e               upd_kind;

    // Route all but the last increment line into the tree, zero-padded.
    if (N_INC > 1) begin : g_multi
        assign tree_bits = TREE_IN'(inc_i[N_INC-2:0]);
    end else begin : g_single
        assign tree_bits = '0;
    end

    assign last_inc = inc_i[N_INC-1];

    apc_popcount_tree #(.CNT_W(CNT_W)) u_tree (
        .bits_i(tree_bits),
        .sum_o (tree_sum)
    );

    // Final adder: stored count plus tree sum plus the last line as carry-in.
    apc_rca #(.W(CNT_W)) u_final (
        .a_i(count_q),
        .b_i(tree_sum),
        .c_i(last_inc),
        .s_o(nxt_count),
        .c_o(nxt_carry)
    );

    // Select the kind of update for this cycle.
    always_comb begin
        upd_kind = pick_update(load_i, en_i);
    end

    // Count and carry registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            carry_q <= 1'b0;
        end else begin
            case (upd_kind)
                UPD_LOAD: begin
                    count_q <= load_val_i;
                    carry_q <= 1'b0;
                end
                UPD_ADD: begin
                    count_q <= nxt_count;
                    carry_q <= nxt_carry;
                end
                default: begin
                    count_q <= count_q;
                    carry_q <= carry_q;
                end
            endcase
        end
    end

    assign count_o = count_q;
    assign carry_o = carry_q;

    // R1: reset clears both outputs on the next edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && !carry_o));

    // R2: a load presets the count and clears the flag.
    a_r2_load_presets: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_o == $past(load_val_i) && !carry_o));

    // R5: no load and no enable leaves both outputs unchanged.
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !en_i) |=> ($stable(count_o) && $stable(carry_o)));

    // R3 and R4: an enabled update adds the number of set lines; the flag is the overflow.
    a_r3_r4_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i) |=>
        ({carry_o, count_o} == ({1'b0, $past(count_o)}
                                + (CNT_W+1)'($past($countones(inc_i))))));

    // R6: the adder tree result equals the number of ones on its inputs.
    a_r6_tree_weight: assert property (@(posedge clk) disable iff (!rst_n)
        tree_sum == CNT_W'($countones(tree_bits)));

endmodule

// File: tb/acc_par_counter_tb_top.sv
// Directed bench for acc_par_counter: one task per scenario, each checking
// its own results against a modulo-2^q reference accumulator.
module acc_par_counter_tb_top;

    localparam int CNT_W   = 4;
    localparam int N_INC   = 16;
    localparam int MODV    = 1 << CNT_W;
    localparam int WD_CYC  = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_i = 1'b0;
    logic [CNT_W-1:0] load_val_i = '0;
    logic             en_i = 1'b0;
    logic [N_INC-1:0] inc_i = '0;
    logic [CNT_W-1:0] count_o;
    logic             carry_o;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_cnt  = 0;
    int ref_cy   = 0;
    bit done     = 1'b0;

    acc_par_counter #(.CNT_W(CNT_W), .N_INC(N_INC)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .load_val_i(load_val_i),
        .en_i      (en_i),
        .inc_i     (inc_i),
        .count_o   (count_o),
        .carry_o   (carry_o)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Count the ones in an increment vector.
    function automatic int ones(input logic [N_INC-1:0] v);
        int c = 0;
        for (int i = 0; i < N_INC; i++) begin
            c += int'(v[i]);
        end
        return c;
    endfunction

    // Compare both outputs with the reference model.
    task automatic check(input string tag);
        n_checks++;
        if (int'(count_o) != ref_cnt) begin
            n_fail++;
            $display("FAIL %s count: actual %0d expected %0d", tag, count_o, ref_cnt);
        end
        n_checks++;
        if (int'(carry_o) != ref_cy) begin
            n_fail++;
            $display("FAIL %s carry: actual %0d expected %0d", tag, carry_o, ref_cy);
        end
    endtask

    // Drive one cycle on the falling edge, then sample 1 ns after the rising edge (R9).
    task automatic step(input logic ld, input int lv, input logic en,
                        input logic [N_INC-1:0] inc, input string tag);
        int s;
        @(negedge clk);
        load_i     = ld;
        load_val_i = CNT_W'(lv);
        en_i       = en;
        inc_i      = inc;
        @(posedge clk);
        #1;
        if (ld) begin
            ref_cnt = lv % MODV;
            ref_cy  = 0;
        end else if (en) begin
            s       = ref_cnt + ones(inc);
            ref_cnt = s % MODV;
            ref_cy  = (s >= MODV) ? 1 : 0;
        end
        check(tag);
    endtask

    // R1: reset with busy inputs still clears everything.
    task automatic t_reset;
        @(negedge clk);
        rst_n  = 1'b0;
        en_i   = 1'b1;
        load_i = 1'b0;
        inc_i  = '1;
        repeat (2) @(posedge clk);
        #1;
        ref_cnt = 0;
        ref_cy  = 0;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;
        en_i  = 1'b0;
        inc_i = '0;
    endtask

    // R2: load beats enable and clears a set flag.
    task automatic t_load;
        step(1'b1, 9, 1'b1, '1, "R2");
        step(1'b0, 0, 1'b1, N_INC'(16'h00FF), "R2 setup");
        step(1'b1, 3, 1'b1, '1, "R2");
        step(1'b1, 15, 1'b0, '0, "R2");
    endtask

    // R3/R4: several increment patterns, with and without wrap.
    task automatic t_add;
        step(1'b1, 0, 1'b0, '0, "R3 setup");
        step(1'b0, 0, 1'b1, N_INC'(16'h0001), "R3");
        step(1'b0, 0, 1'b1, N_INC'(16'h5555), "R3");
        step(1'b0, 0, 1'b1, N_INC'(16'h0F00), "R4");
        step(1'b0, 0, 1'b1, N_INC'(16'h0000), "R4");
        step(1'b1, 14, 1'b0, '0, "R4 setup");
        step(1'b0, 0, 1'b1, N_INC'(16'h0421), "R4");
    endtask

    // R5: holding keeps count and a set flag despite busy increment lines.
    task automatic t_hold;
        step(1'b1, 13, 1'b0, '0, "R5 setup");
        step(1'b0, 0, 1'b1, N_INC'(16'h00F0), "R5 setup");
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 0, 1'b0, '1, "R5");
        end
    endtask

    // R6: the last line, which feeds the carry-in, counts as one; all lines add N_INC.
    task automatic t_last_line;
        step(1'b1, 0, 1'b0, '0, "R6 setup");
        step(1'b0, 0, 1'b1, N_INC'(1) << (N_INC-1), "R6");
        step(1'b0, 0, 1'b1, '1, "R6");
    endtask

    // R7: preset 2^q - k with k = 5, then feed 2, 2 and 1 ones.
    task automatic t_threshold;
        step(1'b1, MODV - 5, 1'b0, '0, "R7 setup");
        step(1'b0, 0, 1'b1, N_INC'(16'h8001), "R7");
        step(1'b0, 0, 1'b1, N_INC'(16'h0300), "R7");
        step(1'b0, 0, 1'b1, N_INC'(16'h0010), "R7");
    endtask

    // R8: a single line behaves as a plain up counter and wraps from 15.
    task automatic t_single_line;
        step(1'b1, 13, 1'b0, '0, "R8 setup");
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 0, 1'b1, N_INC'(1), "R8");
        end
        step(1'b0, 0, 1'b1, N_INC'(1), "R8");
    endtask

    // R3: mixed random loads, enables and increment vectors.
    task automatic t_random;
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 8) == 0, int'($urandom % MODV), ($urandom % 4) != 0,
                 N_INC'($urandom), "R3 random");
        end
    endtask

    // Main sequence.
    initial begin
        t_reset;
        t_load;
        t_add;
        t_hold;
        t_last_line;
        t_threshold;
        t_single_line;
        t_random;
        t_reset;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule